// File: doc/BRIEF.md
# Four-Port Unified Memory Access Scheduler

This block sits in front of one on-chip memory that holds both instructions and data, with no fixed boundary between them. The low part of the byte address space is writable RAM. The upper part is read-only ROM whose contents come from a fixed formula. Four requesters compete for it: two 64-bit processor data ports, a 256-bit instruction-line fetch port and a 32-bit port on the peripheral side. In any cycle the scheduler grants at most three of them, and each granted access completes in that cycle.

Every port uses a valid/ready handshake. A requester raises valid with its address, and with its write flag and data where it has them. It holds them until ready is high in the same cycle, which marks the grant. One cycle after the grant the port's response strobe rises. It carries read data, or an error flag when the port tried to write into the ROM.

When all four ports ask at once, the peripheral port is the one that waits. In the next cycle it goes first, so it cannot starve. Two processor ports aimed at the same 64-bit word are split over two cycles, and processor port 0 goes first.

Top module: `msched_top`

## Requirements
- R1: A port's ready is high only while its valid is high. When at most three ports request and the two processor ports do not target the same word, every requesting port is granted in that cycle.
- R2: No more than three readies are high in any cycle.
- R3: When all four ports request, with no same-word processor pair and no pending priority for the peripheral port, the peripheral port is deferred and the other three are granted.
- R4: A peripheral request that was deferred and is still held is granted in the next cycle. In that cycle the order is peripheral, processor 0, processor 1, fetch, so with four requests the fetch port waits.
- R5: When both processor ports request the same 64-bit word (byte address bits [ADDR_W-1:3] equal), processor 0 is granted and processor 1 is not.
- R6: Each port's response strobe rises exactly one cycle after its grant. Read data shows memory as it stood before any write granted in the same cycle. A processor read returns the 64-bit word at addr[ADDR_W-1:3]. A fetch returns the 32-byte aligned line, with the lowest-addressed word in bits [63:0]. A peripheral read returns bits [31:0] of its word when addr[2]=0 and bits [63:32] when addr[2]=1. A granted write returns zero data.
- R7: Byte addresses below RAM_WORDS*8 map to RAM and the rest map to ROM. ROM word k, counted from the start of ROM, reads (k * 64'h9E3779B97F4A7C15) ^ 64'hA5A500000000_5A5A.
- R8: A granted write into ROM completes with the port's error flag set in its response and leaves memory unchanged. Every other response has the error flag clear.
- R9: Writes granted in the same cycle take effect in the order processor 0, processor 1, peripheral, so the later one wins on any bytes they share. A peripheral write replaces only the 32-bit half that addr[2] selects.
- R10: After reset all RAM words read zero, no response strobe is high and the peripheral port has no pending priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu0_valid | input | 1 | Processor port 0 request |
| cpu0_ready | output | 1 | Processor port 0 grant |
| cpu0_we | input | 1 | Processor port 0 write flag |
| cpu0_addr | input | ADDR_W | Processor port 0 byte address |
| cpu0_wdata | input | 64 | Processor port 0 write data |
| cpu0_rvalid | output | 1 | Processor port 0 response strobe |
| cpu0_rdata | output | 64 | Processor port 0 read data |
| cpu0_err | output | 1 | Processor port 0 ROM-write error |
| cpu1_valid | input | 1 | Processor port 1 request |
| cpu1_ready | output | 1 | Processor port 1 grant |
| cpu1_we | input | 1 | Processor port 1 write flag |
| cpu1_addr | input | ADDR_W | Processor port 1 byte address |
| cpu1_wdata | input | 64 | Processor port 1 write data |
| cpu1_rvalid | output | 1 | Processor port 1 response strobe |
| cpu1_rdata | output | 64 | Processor port 1 read data |
| cpu1_err | output | 1 | Processor port 1 ROM-write error |
| ifet_valid | input | 1 | Fetch port request |
| ifet_ready | output | 1 | Fetch port grant |
| ifet_addr | input | ADDR_W | Fetch port byte address |
| ifet_rvalid | output | 1 | Fetch port response strobe |
| ifet_rdata | output | 256 | Fetched line |
| per_valid | input | 1 | Peripheral port request |
| per_ready | output | 1 | Peripheral port grant |
| per_we | input | 1 | Peripheral port write flag |
| per_addr | input | ADDR_W | Peripheral port byte address |
| per_wdata | input | 32 | Peripheral port write data |
| per_rvalid | output | 1 | Peripheral port response strobe |
| per_rdata | output | 32 | Peripheral port read data |
| per_err | output | 1 | Peripheral port ROM-write error |

## Verification
The assertions watch the grant logic on every cycle: the three-grant limit, ready only with valid, full service when three or fewer ports ask, the peripheral deferral and its next-cycle priority, and the same-word split between the processor ports. They also check that each response follows its grant one cycle later and that the error flag appears only after a ROM write. The contents of the memory are left to the bench scenarios. These cover read-before-write ordering inside a cycle, the merge of a peripheral half-word write with a processor write, the ROM formula, and proof that a rejected ROM write left the word as it was.

// File: rtl/msched_pkg.sv
package msched_pkg;
  localparam int NPORT = 4;
  localparam int IX_C0 = 0;
  localparam int IX_C1 = 1;
  localparam int IX_IF = 2;
  localparam int IX_PE = 3;

  // Fixed contents of ROM word k (k counted from the ROM base).
  function automatic logic [63:0] rom_pattern(input logic [31:0] k);
    return (64'(k) * 64'h9E37_79B9_7F4A_7C15) ^ 64'hA5A5_0000_0000_5A5A;
  endfunction

  // Number of set bits in a grant vector.
  function automatic int unsigned grant_count(input logic [NPORT-1:0] g);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NPORT; i++) n += 32'(g[i]);
    return n;
  endfunction
endpackage

// File: rtl/msched_arbiter.sv
module msched_arbiter
  import msched_pkg::*;
#(
  parameter int WAW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic [WAW-1:0]   c0_word,
  input  logic [WAW-1:0]   c1_word,
  output logic [NPORT-1:0] grant
);
  localparam int MAX_GRANTS = NPORT - 1;

  logic             boost_q;    // peripheral was deferred last cycle
  logic             same_word;  // processor ports collide on one word
  logic [NPORT-1:0] elig;
  logic             full_load;

  assign same_word = req[IX_C0] & req[IX_C1] & (c0_word == c1_word);

  always_comb begin
    elig = req;
    if (same_word) elig[IX_C1] = 1'b0;
    full_load = (grant_count(elig) > MAX_GRANTS);
    grant = elig;
    if (full_load) begin
      if (boost_q) grant[IX_IF] = 1'b0;
      else         grant[IX_PE] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) boost_q <= 1'b0;
    else        boost_q <= req[IX_PE] & ~grant[IX_PE];
  end

  // R1: ready only with valid
  a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  // R1: light load is served in full
  a_r1_light_load_served: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) <= 3 && !same_word) |-> grant == req);
  // R2: at most three grants per cycle
  a_r2_max_three: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= 3);
  // R3: peripheral is deferred first under full load
  a_r3_defer_periph: assert property (@(posedge clk) disable iff (!rst_n)
    (&req && !same_word && !boost_q) |-> grant == 4'b0111);
  // R4: a deferred, held peripheral request wins next cycle
  a_r4_no_starve: assert property (@(posedge clk) disable iff (!rst_n)
    (req[IX_PE] && !grant[IX_PE]) |=> (!req[IX_PE] || grant[IX_PE]));
  // R5: same-word pair serialized, port 0 first
  a_r5_same_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    same_word |-> (grant[IX_C0] && !grant[IX_C1]));
endmodule

// File: rtl/msched_store.sv
module msched_store
  import msched_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int RAM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORT-1:0]  grant,
  input  logic [NPORT-1:0]  wr,
  input  logic [ADDR_W-1:0] a_c0,
  input  logic [ADDR_W-1:0] a_c1,
  input  logic [ADDR_W-1:0] a_if,
  input  logic [ADDR_W-1:0] a_pe,
  input  logic [63:0]       wd_c0,
  input  logic [63:0]       wd_c1,
  input  logic [31:0]       wd_pe,
  output logic [63:0]       rd_c0,
  output logic [63:0]       rd_c1,
  output logic [255:0]      rd_if,
  output logic [31:0]       rd_pe,
  output logic [NPORT-1:0]  rom_hit
);
  localparam int WAW       = ADDR_W - 3;
  localparam int RAW       = $clog2(RAM_WORDS);
  localparam int LINE_WDS  = 4;
  localparam int LINE_SH   = $clog2(LINE_WDS);

  logic [63:0] ram [RAM_WORDS];

  function automatic logic in_rom(input logic [ADDR_W-1:0] a);
    return 32'(a[ADDR_W-1:3]) >= 32'(RAM_WORDS);
  endfunction

  function automatic logic [63:0] word_at(input logic [WAW-1:0] w);
    if (32'(w) < 32'(RAM_WORDS)) return ram[w[RAW-1:0]];
    else                         return rom_pattern(32'(w) - 32'(RAM_WORDS));
  endfunction

  assign rom_hit[IX_C0] = in_rom(a_c0);
  assign rom_hit[IX_C1] = in_rom(a_c1);
  assign rom_hit[IX_IF] = in_rom(a_if);
  assign rom_hit[IX_PE] = in_rom(a_pe);

  logic [63:0] pe_word;

  always_comb begin
    rd_c0   = word_at(a_c0[ADDR_W-1:3]);
    rd_c1   = word_at(a_c1[ADDR_W-1:3]);
    pe_word = word_at(a_pe[ADDR_W-1:3]);
    rd_pe   = a_pe[2] ? pe_word[63:32] : pe_word[31:0];
  end

  for (genvar k = 0; k < LINE_WDS; k++) begin : g_line
    logic [WAW-1:0] lw;
    assign lw = {a_if[ADDR_W-1:3+LINE_SH], LINE_SH'(k)};
    assign rd_if[64*k +: 64] = word_at(lw);
  end

  // Writes in fixed order: processor 0, processor 1, peripheral.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_WORDS; i++) ram[i] <= '0;
    end else begin
      if (grant[IX_C0] && wr[IX_C0] && !rom_hit[IX_C0])
        ram[a_c0[RAW+2:3]] <= wd_c0;
      if (grant[IX_C1] && wr[IX_C1] && !rom_hit[IX_C1])
        ram[a_c1[RAW+2:3]] <= wd_c1;
      if (grant[IX_PE] && wr[IX_PE] && !rom_hit[IX_PE]) begin
        if (a_pe[2]) ram[a_pe[RAW+2:3]][63:32] <= wd_pe;
        else         ram[a_pe[RAW+2:3]][31:0]  <= wd_pe;
      end
    end
  end
endmodule

// File: rtl/msched_top.sv
module msched_top
  import msched_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int RAM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu0_valid,
  output logic              cpu0_ready,
  input  logic              cpu0_we,
  input  logic [ADDR_W-1:0] cpu0_addr,
  input  logic [63:0]       cpu0_wdata,
  output logic              cpu0_rvalid,
  output logic [63:0]       cpu0_rdata,
  output logic              cpu0_err,
  input  logic              cpu1_valid,
  output logic              cpu1_ready,
  input  logic              cpu1_we,
  input  logic [ADDR_W-1:0] cpu1_addr,
  input  logic [63:0]       cpu1_wdata,
  output logic              cpu1_rvalid,
  output logic [63:0]       cpu1_rdata,
  output logic              cpu1_err,
  input  logic              ifet_valid,
  output logic              ifet_ready,
  input  logic [ADDR_W-1:0] ifet_addr,
  output logic              ifet_rvalid,
  output logic [255:0]      ifet_rdata,
  input  logic              per_valid,
  output logic              per_ready,
  input  logic              per_we,
  input  logic [ADDR_W-1:0] per_addr,
  input  logic [31:0]       per_wdata,
  output logic              per_rvalid,
  output logic [31:0]       per_rdata,
  output logic              per_err
);
  localparam int WAW = ADDR_W - 3;

  logic [NPORT-1:0] req, grant, wr, rom_hit, rom_wr;
  logic [63:0]      rd_c0, rd_c1;
  logic [255:0]     rd_if;
  logic [31:0]      rd_pe;

  assign req    = {per_valid, ifet_valid, cpu1_valid, cpu0_valid};
  assign wr     = {per_we, 1'b0, cpu1_we, cpu0_we};
  assign rom_wr = grant & wr & rom_hit;

  msched_arbiter #(.WAW(WAW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req),
    .c0_word(cpu0_addr[ADDR_W-1:3]), .c1_word(cpu1_addr[ADDR_W-1:3]),
    .grant(grant)
  );

  msched_store #(.ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n), .grant(grant), .wr(wr),
    .a_c0(cpu0_addr), .a_c1(cpu1_addr), .a_if(ifet_addr), .a_pe(per_addr),
    .wd_c0(cpu0_wdata), .wd_c1(cpu1_wdata), .wd_pe(per_wdata),
    .rd_c0(rd_c0), .rd_c1(rd_c1), .rd_if(rd_if), .rd_pe(rd_pe),
    .rom_hit(rom_hit)
  );

  assign cpu0_ready = grant[IX_C0];
  assign cpu1_ready = grant[IX_C1];
  assign ifet_ready = grant[IX_IF];
  assign per_ready  = grant[IX_PE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu0_rvalid <= 1'b0; cpu0_rdata <= '0; cpu0_err <= 1'b0;
      cpu1_rvalid <= 1'b0; cpu1_rdata <= '0; cpu1_err <= 1'b0;
      ifet_rvalid <= 1'b0; ifet_rdata <= '0;
      per_rvalid  <= 1'b0; per_rdata  <= '0; per_err  <= 1'b0;
    end else begin
      cpu0_rvalid <= grant[IX_C0];
      cpu0_rdata  <= (grant[IX_C0] && !cpu0_we) ? rd_c0 : '0;
      cpu0_err    <= rom_wr[IX_C0];
      cpu1_rvalid <= grant[IX_C1];
      cpu1_rdata  <= (grant[IX_C1] && !cpu1_we) ? rd_c1 : '0;
      cpu1_err    <= rom_wr[IX_C1];
      ifet_rvalid <= grant[IX_IF];
      ifet_rdata  <= grant[IX_IF] ? rd_if : '0;
      per_rvalid  <= grant[IX_PE];
      per_rdata   <= (grant[IX_PE] && !per_we) ? rd_pe : '0;
      per_err     <= rom_wr[IX_PE];
    end
  end

  // R6: response strobe follows grant by one cycle
  a_r6_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant[IX_C0] |=> cpu0_rvalid);
  a_r6_rsp_only_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    per_rvalid |-> $past(per_ready));
  // R8: error flag only on a response to a ROM write
  a_r8_err_needs_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    cpu1_err |-> (cpu1_rvalid && $past(cpu1_we && rom_hit[IX_C1])));
  a_r8_rom_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rom_wr[IX_PE] |=> per_err);
endmodule

// File: tb/tb_msched_top.sv
module tb_msched_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int RAM_WORDS  = 64;
  localparam int N_RANDOM   = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic cpu0_valid, cpu0_ready, cpu0_we, cpu0_rvalid, cpu0_err;
  logic [ADDR_W-1:0] cpu0_addr; logic [63:0] cpu0_wdata, cpu0_rdata;
  logic cpu1_valid, cpu1_ready, cpu1_we, cpu1_rvalid, cpu1_err;
  logic [ADDR_W-1:0] cpu1_addr; logic [63:0] cpu1_wdata, cpu1_rdata;
  logic ifet_valid, ifet_ready, ifet_rvalid;
  logic [ADDR_W-1:0] ifet_addr; logic [255:0] ifet_rdata;
  logic per_valid, per_ready, per_we, per_rvalid, per_err;
  logic [ADDR_W-1:0] per_addr; logic [31:0] per_wdata, per_rdata;

  msched_top #(.ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS)) dut (.*);

  int n_checks = 0, n_fail = 0;
  logic [63:0] ref_ram [RAM_WORDS];
  logic pv[4], pwe[4];
  logic [ADDR_W-1:0] pa[4];
  logic [63:0] pwd[4];
  logic boost = 1'b0;
  logic auto_fill = 1'b0;
  logic exp_rv[4], exp_err[4];
  logic [255:0] exp_rd[4];
  string exp_tag[4];

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [63:0] bench_rom(input int k);
    logic [63:0] m;
    m = 64'h9E37_79B9_7F4A_7C15;
    return 64'hA5A5_0000_0000_5A5A ^ (64'(k) * m);
  endfunction

  function automatic logic [63:0] ref_word(input int w);
    return (w < RAM_WORDS) ? ref_ram[w] : bench_rom(w - RAM_WORDS);
  endfunction

  task automatic set_req(input int p, input logic we, input int addr, input logic [63:0] wd);
    pv[p] = 1'b1; pwe[p] = (p == 2) ? 1'b0 : we; pa[p] = ADDR_W'(addr); pwd[p] = wd;
  endtask

  task automatic drive();
    cpu0_valid = pv[0]; cpu0_we = pwe[0]; cpu0_addr = pa[0]; cpu0_wdata = pwd[0];
    cpu1_valid = pv[1]; cpu1_we = pwe[1]; cpu1_addr = pa[1]; cpu1_wdata = pwd[1];
    ifet_valid = pv[2]; ifet_addr = pa[2];
    per_valid = pv[3]; per_we = pwe[3]; per_addr = pa[3]; per_wdata = pwd[3][31:0];
  endtask

  task automatic fill_random();
    for (int p = 0; p < 4; p++) begin
      if (!pv[p] && ($urandom % 100) < 70) begin
        int r, w;
        r = int'($urandom % 4);
        case (r)
          0: w = int'($urandom % 8);
          1: w = int'($urandom % RAM_WORDS);
          2: w = RAM_WORDS + int'($urandom % RAM_WORDS);
          default: w = RAM_WORDS - 4 + int'($urandom % 8);
        endcase
        set_req(p, 1'($urandom % 2), w * 8 + ((p == 3) ? int'($urandom % 2) * 4 : 0),
                {$urandom, $urandom});
      end
    end
  endtask

  task automatic check_resp();
    logic rv[4], er[4];
    logic [255:0] rd[4];
    rv = '{cpu0_rvalid, cpu1_rvalid, ifet_rvalid, per_rvalid};
    er = '{cpu0_err, cpu1_err, 1'b0, per_err};
    rd = '{256'(cpu0_rdata), 256'(cpu1_rdata), ifet_rdata, 256'(per_rdata)};
    for (int p = 0; p < 4; p++) begin
      chk(rv[p] == exp_rv[p], exp_rv[p] ? "R6" : "R10", "response strobe",
          256'(rv[p]), 256'(exp_rv[p]));
      if (exp_rv[p]) begin
        chk(rd[p] == exp_rd[p], exp_tag[p], "read data", rd[p], exp_rd[p]);
        chk(er[p] == exp_err[p], "R8", "error flag", 256'(er[p]), 256'(exp_err[p]));
      end
    end
  endtask

  task automatic evaluate();
    logic [3:0] eg, got;
    logic conflict;
    int order[4];
    int n, w;
    logic rom;
    logic [63:0] x;
    string tag;
    got = {per_ready, ifet_ready, cpu1_ready, cpu0_ready};
    conflict = pv[0] && pv[1] && (pa[0][ADDR_W-1:3] == pa[1][ADDR_W-1:3]);
    order = boost ? '{3, 0, 1, 2} : '{0, 1, 2, 3};
    eg = '0; n = 0;
    for (int k = 0; k < 4; k++)
      if (pv[order[k]] && !(order[k] == 1 && conflict) && n < 3) begin
        eg[order[k]] = 1'b1; n++;
      end
    if (conflict) tag = "R5";
    else if (pv[0] && pv[1] && pv[2] && pv[3]) tag = boost ? "R4" : "R3";
    else tag = "R1";
    chk(got == eg, tag, "grant vector", 256'(got), 256'(eg));
    chk($countones(got) <= 3, "R2", "grant count", 256'($countones(got)), 256'(3));
    // reads see memory before this cycle's writes
    for (int p = 0; p < 4; p++) begin
      exp_rv[p] = eg[p]; exp_err[p] = 1'b0; exp_rd[p] = '0; exp_tag[p] = "R6";
      if (eg[p]) begin
        w = int'(pa[p]) / 8;
        rom = (w >= RAM_WORDS);
        if (rom) exp_tag[p] = "R7";
        if (pwe[p]) begin
          exp_err[p] = rom;
          exp_tag[p] = "R8";
        end else if (p == 2) begin
          for (int k = 0; k < 4; k++) exp_rd[p][64*k +: 64] = ref_word((w / 4) * 4 + k);
        end else if (p == 3) begin
          x = ref_word(w);
          exp_rd[p] = 256'(pa[p][2] ? x[63:32] : x[31:0]);
        end else begin
          exp_rd[p] = 256'(ref_word(w));
        end
      end
    end
    // writes in order 0, 1, peripheral
    for (int p = 0; p < 4; p++) begin
      w = int'(pa[p]) / 8;
      if (eg[p] && pwe[p] && w < RAM_WORDS) begin
        if (p == 3) begin
          if (pa[p][2]) ref_ram[w][63:32] = pwd[p][31:0];
          else          ref_ram[w][31:0]  = pwd[p][31:0];
        end else ref_ram[w] = pwd[p];
      end
    end
    boost = pv[3] && !eg[3];
    for (int p = 0; p < 4; p++) if (eg[p]) pv[p] = 1'b0;
  endtask

  task automatic run_cycle();
    @(negedge clk);
    check_resp();
    if (auto_fill) fill_random();
    drive();
    #1;
    evaluate();
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      pv[p] = 1'b0; pwe[p] = 1'b0; pa[p] = '0; pwd[p] = '0;
      exp_rv[p] = 1'b0; exp_err[p] = 1'b0; exp_rd[p] = '0; exp_tag[p] = "R6";
    end
    for (int i = 0; i < RAM_WORDS; i++) ref_ram[i] = '0;
    void'($urandom(32'd4242));
    drive();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: idle after reset, RAM reads zero
    run_cycle();
    set_req(0, 1'b0, 5 * 8, 64'd0);
    run_cycle();
    @(posedge clk); #1;
    chk(cpu0_rdata == 64'd0 && cpu0_rvalid, "R10", "RAM word after reset",
        256'(cpu0_rdata), 256'd0);

    // R3 then R4: full load, peripheral waits, then leads and fetch waits
    set_req(0, 1'b0, 1 * 8, 0); set_req(1, 1'b0, 2 * 8, 0);
    set_req(2, 1'b0, 0, 0);     set_req(3, 1'b0, 3 * 8 + 4, 0);
    run_cycle();
    set_req(0, 1'b1, 8 * 8, 64'h0123_4567_89AB_CDEF);
    set_req(1, 1'b0, 9 * 8, 0); set_req(2, 1'b0, 64 * 8, 0);
    run_cycle();
    run_cycle();

    // R5: same word, writer on port 0 goes first, port 1 reads new value
    set_req(0, 1'b1, 4 * 8, 64'hDEAD_BEEF_0000_1111);
    set_req(1, 1'b0, 4 * 8, 0);
    run_cycle();
    run_cycle();
    @(posedge clk); #1;
    chk(cpu1_rvalid && cpu1_rdata == 64'hDEAD_BEEF_0000_1111, "R5",
        "port 1 after serialization", 256'(cpu1_rdata), 256'(64'hDEAD_BEEF_0000_1111));

    // R8: ROM write is rejected and leaves the word alone; R7 ROM formula
    set_req(0, 1'b1, 600, 64'hFFFF_FFFF_FFFF_FFFF);
    run_cycle();
    set_req(1, 1'b0, 600, 0);
    run_cycle();
    run_cycle();
    chk(cpu1_rdata == bench_rom(600 / 8 - RAM_WORDS), "R7", "ROM word after rejected write",
        256'(cpu1_rdata), 256'(bench_rom(600 / 8 - RAM_WORDS)));

    // R9: processor write then peripheral upper half in the same cycle
    set_req(0, 1'b1, 6 * 8, 64'h1111_2222_3333_4444);
    set_req(3, 1'b1, 6 * 8 + 4, 64'h0000_0000_AAAA_BBBB);
    run_cycle();
    set_req(0, 1'b0, 6 * 8, 0);
    run_cycle();
    @(posedge clk); #1;
    chk(cpu0_rdata == 64'hAAAA_BBBB_3333_4444, "R9", "merged word",
        256'(cpu0_rdata), 256'(64'hAAAA_BBBB_3333_4444));

    auto_fill = 1'b1;
    for (int c = 0; c < N_RANDOM; c++) run_cycle();
    auto_fill = 1'b0;
    for (int c = 0; c < 8; c++) run_cycle();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule